// File: doc/BRIEF.md
# Ping-pong OUT endpoint bank manager

This block sits behind a USB packet engine on a device OUT endpoint and owns two receive banks that are filled in strict turn. The packet engine hands it a payload as a start marker, a run of data bytes and an end marker that carries the CRC verdict. The block picks the bank for each payload, stores the bytes and the byte count, raises that bank's received flag and tells the packet engine whether to answer ACK or NAK. A payload with a bad CRC leaves no trace and gets no handshake.

On the processor side, firmware picks a bank and an address to read stored bytes and the stored length, and clears a bank's flag with a one-cycle pulse once it has consumed the data. Because the host can fill both banks before firmware runs, the block keeps a read pointer that names the bank to service next. The interrupt line is high while any flag is set. The processor can read one bank while the USB side writes the other.

Top module: `pp_out_ep`

## Requirements
- R1: After reset the write pointer `wr_bank` is 0. It toggles once per accepted payload, so accepted payloads land in bank 0, bank 1, bank 0 and so on.
- R2: A payload is accepted when `rx_end` arrives with `rx_crc_ok`=1 and the target bank's flag was clear at `rx_start`. The flag `bank_full[b]` of the target bank b then rises in the cycle after the `rx_end` cycle. Bit 0 is bank 0 and bit 1 is bank 1.
- R3: `irq` is 1 exactly while at least one bit of `bank_full` is 1.
- R4: A flag set by hardware stays set until a cycle with `cpu_clr[b]`=1. The hardware never clears it. A pulse on `cpu_clr[b]` while the flag is clear has no effect.
- R5: Each payload that ends with a good CRC yields a one-cycle `hs_valid` pulse in the cycle after `rx_end`. `hs_ack`=1 means ACK and `hs_ack`=0 means NAK. On ACK the flag rises in the same cycle as the pulse.
- R6: `rd_bank` is 0 after reset. It toggles only in the cycle after `cpu_clr[rd_bank]` is pulsed while that bank's flag is set. Clearing the other bank leaves `rd_bank` unchanged.
- R7: With `cpu_bank`=b, `cpu_len` shows the byte count stored for bank b. `cpu_rdata` shows the byte at `cpu_addr`, with address 0 holding the first byte received. The count may be 0.
- R8: If the target bank's flag is set at `rx_start`, the payload is discarded and answered with NAK. The write pointer, the flags and that bank's bytes and count are unchanged.
- R9: A payload ending with `rx_crc_ok`=0 gets no handshake. It sets no flag and does not move the write pointer.
- R10: Bytes beyond `MAX_BYTES` in one payload are dropped, and the stored count saturates at `MAX_BYTES`.
- R11: While bank b is flagged, its stored bytes and count read back unchanged even while a payload is being written into the other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_start | input | 1 | Payload start marker, on a cycle of its own |
| rx_valid | input | 1 | `rx_data` holds a payload byte |
| rx_data | input | DATA_W | Payload byte |
| rx_end | input | 1 | Payload end marker, on a cycle of its own |
| rx_crc_ok | input | 1 | CRC verdict, sampled with `rx_end` |
| hs_valid | output | 1 | Handshake request pulse |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK, valid with `hs_valid` |
| wr_bank | output | 1 | Bank that receives the next payload |
| bank_full | output | 2 | Per-bank received flags |
| irq | output | 1 | Endpoint interrupt |
| rd_bank | output | 1 | Bank firmware should service next |
| cpu_bank | input | 1 | Bank selected for processor reads |
| cpu_addr | input | ADDR_W | Byte address within the selected bank |
| cpu_rdata | output | DATA_W | Stored byte at `cpu_addr` |
| cpu_len | output | CNT_W | Stored byte count of the selected bank |
| cpu_clr | input | 2 | Per-bank flag clear pulses |

## Verification
The bench builds the block with its default values, 8-bit data and 64-byte banks. A 64-byte payload therefore fills a bank to its last address, and a 70-byte payload runs past that limit and shows the count saturating. Small bank sizes are not needed to reach the interesting states. Both flags set together, a NAK against a full bank, out-of-order clearing and a bad-CRC payload all occur within a few short payloads at this size.

// File: rtl/pp_ep_pkg.sv
`timescale 1ns / 1ps
// Shared types for the ping-pong OUT endpoint.
package pp_ep_pkg;

    // Number of receive banks; the alternation logic assumes two.
    localparam int NUM_BANKS = 2;

    // Receive-side state for the payload in flight.
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_STORE = 2'd1,
        RX_DROP  = 2'd2
    } rx_mode_e;

endpackage

// File: rtl/pp_ep_bank.sv
`timescale 1ns / 1ps
// One receive bank: payload byte storage plus its stored byte count.
// Assumes the writer never targets a bank the processor is still reading.
module pp_ep_bank #(
    parameter int DATA_W    = 8,
    parameter int MAX_BYTES = 64,
    parameter int ADDR_W    = 6,
    parameter int CNT_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              len_load,
    input  logic [CNT_W-1:0]  len_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  len
);

    logic [DATA_W-1:0] mem [MAX_BYTES];

    // Store a payload byte.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Latch the byte count when the payload is committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len <= '0;
        end else if (len_load) begin
            len <= len_in;
        end
    end

    // Asynchronous processor read, zero outside the bank.
    always_comb begin
        rd_data = (int'(rd_addr) < MAX_BYTES) ? mem[rd_addr] : '0;
    end

endmodule

// File: rtl/pp_ep_wr_ctrl.sv
`timescale 1ns / 1ps
// USB-side write control: chooses store or drop at payload start, counts
// bytes, commits good payloads and produces the handshake request.
// Assumes start and end markers come on cycles without data.
module pp_ep_wr_ctrl
    import pp_ep_pkg::*;
#(
    parameter int MAX_BYTES = 64,
    parameter int ADDR_W    = 6,
    parameter int CNT_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic              rx_end,
    input  logic              rx_crc_ok,
    input  logic [1:0]        bank_full,
    output logic              wr_bank,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        commit,
    output logic [CNT_W-1:0]  commit_len,
    output logic              hs_valid,
    output logic              hs_ack
);

    rx_mode_e         mode;
    logic [CNT_W-1:0] cnt;
    logic             room;
    logic             accept;
    logic             refuse;

    // Decode this cycle's write, commit and refusal.
    always_comb begin
        room       = int'(cnt) < MAX_BYTES;
        wr_en      = (mode == RX_STORE) && rx_valid && !rx_start && !rx_end && room;
        wr_addr    = cnt[ADDR_W-1:0];
        commit_len = cnt;
        accept     = (mode == RX_STORE) && rx_end && !rx_start && rx_crc_ok;
        refuse     = (mode == RX_DROP) && rx_end && !rx_start && rx_crc_ok;
        commit     = {accept & wr_bank, accept & ~wr_bank};
    end

    // Track payload mode, byte count, write pointer and handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= RX_IDLE;
            cnt      <= '0;
            wr_bank  <= 1'b0;
            hs_valid <= 1'b0;
            hs_ack   <= 1'b0;
        end else begin
            hs_valid <= accept | refuse;
            hs_ack   <= accept;
            if (rx_start) begin
                mode <= bank_full[wr_bank] ? RX_DROP : RX_STORE;
                cnt  <= '0;
            end else if (rx_end) begin
                mode <= RX_IDLE;
                if (accept) begin
                    wr_bank <= ~wr_bank;
                end
            end else if (wr_en) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pp_ep_rd_ctrl.sv
`timescale 1ns / 1ps
// Processor-side flag control: holds the per-bank received flags, the
// next-bank-to-service pointer and the interrupt.
// Assumes commit pulses only target a bank whose flag is clear.
module pp_ep_rd_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] commit,
    input  logic [1:0] cpu_clr,
    output logic [1:0] full,
    output logic       rd_bank,
    output logic       irq
);

    // Set flags on commit, clear them on firmware request, step read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full    <= 2'b00;
            rd_bank <= 1'b0;
        end else begin
            full <= (full & ~cpu_clr) | commit;
            if (cpu_clr[rd_bank] && full[rd_bank]) begin
                rd_bank <= ~rd_bank;
            end
        end
    end

    // Interrupt while any bank waits for service.
    always_comb begin
        irq = |full;
    end

endmodule

// File: rtl/pp_out_ep.sv
`timescale 1ns / 1ps
// Ping-pong OUT endpoint bank manager: steers alternate payloads into two
// banks, flags them for firmware and requests ACK/NAK handshakes.
// Assumes an external packet engine supplies framed payload bytes and CRC.
module pp_out_ep #(
    parameter  int DATA_W    = 8,
    parameter  int MAX_BYTES = 64,
    localparam int ADDR_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_end,
    input  logic              rx_crc_ok,
    output logic              hs_valid,
    output logic              hs_ack,
    output logic              wr_bank,
    output logic [1:0]        bank_full,
    output logic              irq,
    output logic              rd_bank,
    input  logic              cpu_bank,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [CNT_W-1:0]  cpu_len,
    input  logic [1:0]        cpu_clr
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [1:0]        commit;
    logic [CNT_W-1:0]  commit_len;
    logic [DATA_W-1:0] bank_rdata [pp_ep_pkg::NUM_BANKS];
    logic [CNT_W-1:0]  bank_len   [pp_ep_pkg::NUM_BANKS];

    pp_ep_wr_ctrl #(
        .MAX_BYTES (MAX_BYTES),
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W)
    ) u_wr_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_start   (rx_start),
        .rx_valid   (rx_valid),
        .rx_end     (rx_end),
        .rx_crc_ok  (rx_crc_ok),
        .bank_full  (bank_full),
        .wr_bank    (wr_bank),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .commit     (commit),
        .commit_len (commit_len),
        .hs_valid   (hs_valid),
        .hs_ack     (hs_ack)
    );

    pp_ep_rd_ctrl u_rd_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .cpu_clr (cpu_clr),
        .full    (bank_full),
        .rd_bank (rd_bank),
        .irq     (irq)
    );

    for (genvar b = 0; b < pp_ep_pkg::NUM_BANKS; b++) begin : g_bank
        localparam logic SEL = 1'(b);
        pp_ep_bank #(
            .DATA_W    (DATA_W),
            .MAX_BYTES (MAX_BYTES),
            .ADDR_W    (ADDR_W),
            .CNT_W     (CNT_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_bank == SEL)),
            .wr_addr  (wr_addr),
            .wr_data  (rx_data),
            .len_load (commit[b]),
            .len_in   (commit_len),
            .rd_addr  (cpu_addr),
            .rd_data  (bank_rdata[b]),
            .len      (bank_len[b])
        );
    end

    // Processor read mux over the banks.
    always_comb begin
        cpu_rdata = bank_rdata[cpu_bank];
        cpu_len   = bank_len[cpu_bank];
    end

endmodule

// File: rtl/pp_out_ep_chk.sv
`timescale 1ns / 1ps
// Protocol checker for pp_out_ep, attached by bind.
module pp_out_ep_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_start,
    input logic       rx_end,
    input logic       rx_crc_ok,
    input logic       hs_valid,
    input logic       hs_ack,
    input logic       wr_bank,
    input logic [1:0] bank_full,
    input logic       irq,
    input logic       rd_bank,
    input logic [1:0] cpu_clr
);

    assert_ack_toggles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_ack) |-> (wr_bank != $past(wr_bank)));

    assert_flag0_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_full[0]) |-> ($past(wr_bank) == 1'b0));

    assert_flag1_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_full[1]) |-> ($past(wr_bank) == 1'b1));

    assert_irq_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_full != 2'b00) |-> irq);

    assert_irq_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(cpu_clr) != 2'b00));

    assert_flag0_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bank_full[0]) |-> $past(cpu_clr[0]));

    assert_flag1_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bank_full[1]) |-> $past(cpu_clr[1]));

    assert_ack_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_ack) |-> ($rose(bank_full[0]) || $rose(bank_full[1])));

    assert_rd_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_bank) |-> ($past(rd_bank) ? $past(cpu_clr[1]) : $past(cpu_clr[0])));

    assert_nak_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && !hs_ack) |-> $stable(wr_bank));

    assert_crc_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && !rx_start && !rx_crc_ok) |=> !hs_valid);

endmodule

bind pp_out_ep pp_out_ep_chk u_pp_out_ep_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_start  (rx_start),
    .rx_end    (rx_end),
    .rx_crc_ok (rx_crc_ok),
    .hs_valid  (hs_valid),
    .hs_ack    (hs_ack),
    .wr_bank   (wr_bank),
    .bank_full (bank_full),
    .irq       (irq),
    .rd_bank   (rd_bank),
    .cpu_clr   (cpu_clr)
);

// File: tb/test_pp_out_ep.sv
`timescale 1ns / 1ps
// Bench: behavioural reference model stepped alongside the design and
// compared on every clock, plus directed scenario checks.
module test_pp_out_ep;

    localparam int DATA_W    = 8;
    localparam int MAX_BYTES = 64;
    localparam int ADDR_W    = 6;
    localparam int CNT_W     = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_start = 1'b0;
    logic              rx_valid = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic              rx_end = 1'b0;
    logic              rx_crc_ok = 1'b0;
    logic              hs_valid;
    logic              hs_ack;
    logic              wr_bank;
    logic [1:0]        bank_full;
    logic              irq;
    logic              rd_bank;
    logic              cpu_bank = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic [CNT_W-1:0]  cpu_len;
    logic [1:0]        cpu_clr = 2'b00;

    pp_out_ep #(.DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)) i_pp_out_ep (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok),
        .hs_valid(hs_valid), .hs_ack(hs_ack), .wr_bank(wr_bank),
        .bank_full(bank_full), .irq(irq), .rd_bank(rd_bank),
        .cpu_bank(cpu_bank), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
        .cpu_len(cpu_len), .cpu_clr(cpu_clr)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit concurrent = 1'b0;
    bit done = 1'b0;

    // Reference model state.
    int m_flag[2];
    int m_wr, m_rd, m_mode, m_hs_v, m_hs_a;
    int m_bank0[$];
    int m_bank1[$];
    int q_pkt[$];
    int seen_hs_v, seen_hs_a;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int m_len(input int b);
        return (b == 0) ? m_bank0.size() : m_bank1.size();
    endfunction

    function automatic int m_byte(input int b, input int i);
        return (b == 0) ? m_bank0[i] : m_bank1[i];
    endfunction

    // Predict the state after the coming clock edge from the driven inputs.
    task automatic model_step();
        int nv = 0;
        int na = 0;
        int commit_b = -1;
        if (rx_start) begin
            m_mode = (m_flag[m_wr] != 0) ? 2 : 1;
            q_pkt.delete();
        end else if (rx_end) begin
            if (rx_crc_ok && m_mode == 1) begin
                commit_b = m_wr; nv = 1; na = 1;
            end else if (rx_crc_ok && m_mode == 2) begin
                nv = 1;
            end
            m_mode = 0;
        end else if (rx_valid && m_mode == 1 && q_pkt.size() < MAX_BYTES) begin
            q_pkt.push_back(int'(rx_data));
        end
        if (cpu_clr[m_rd] && m_flag[m_rd] != 0) m_rd = 1 - m_rd;
        for (int b = 0; b < 2; b++) if (cpu_clr[b]) m_flag[b] = 0;
        if (commit_b >= 0) begin
            if (commit_b == 0) m_bank0 = q_pkt; else m_bank1 = q_pkt;
            m_flag[commit_b] = 1;
            m_wr = 1 - m_wr;
        end
        m_hs_v = nv;
        m_hs_a = na;
    endtask

    // Compare every observable output with the model.
    task automatic compare();
        int cb = int'(cpu_bank);
        string tag = concurrent ? "R11" : "R7";
        check("R2", "bank_full[0]", int'(bank_full[0]), m_flag[0]);
        check("R2", "bank_full[1]", int'(bank_full[1]), m_flag[1]);
        check("R3", "irq", int'(irq), (m_flag[0] | m_flag[1]));
        check("R5", "hs_valid", int'(hs_valid), m_hs_v);
        if (m_hs_v != 0) check("R5", "hs_ack", int'(hs_ack), m_hs_a);
        check("R1", "wr_bank", int'(wr_bank), m_wr);
        check("R6", "rd_bank", int'(rd_bank), m_rd);
        if (m_flag[cb] != 0) begin
            check(tag, "cpu_len", int'(cpu_len), m_len(cb));
            if (int'(cpu_addr) < m_len(cb))
                check(tag, "cpu_rdata", int'(cpu_rdata), m_byte(cb, int'(cpu_addr)));
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        compare();
    endtask

    // Drive one framed payload; optionally walk the processor read address.
    task automatic send_pkt(input int n, input int seed, input bit crc_ok);
        int cl = m_len(int'(cpu_bank));
        rx_start = 1'b1; tick(); rx_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = 8'((seed + i * 7) & 255);
            if (concurrent && cl > 0) cpu_addr = ADDR_W'(i % cl);
            tick();
        end
        rx_valid = 1'b0;
        rx_end = 1'b1; rx_crc_ok = crc_ok; tick();
        rx_end = 1'b0; rx_crc_ok = 1'b0;
        seen_hs_v = int'(hs_valid);
        seen_hs_a = int'(hs_ack);
        tick();
    endtask

    task automatic clear_bank(input int b);
        cpu_clr[b] = 1'b1; tick(); cpu_clr = 2'b00;
    endtask

    // Read back every byte of a bank through the processor port.
    task automatic read_bank(input int b, input string tag, input int exp_len);
        cpu_bank = 1'(b);
        cpu_addr = '0;
        tick();
        check(tag, "stored length", int'(cpu_len), exp_len);
        for (int i = 0; i < m_len(b); i++) begin
            cpu_addr = ADDR_W'(i);
            tick();
            check(tag, "stored byte", int'(cpu_rdata), m_byte(b, i));
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        m_flag[0] = 0; m_flag[1] = 0;
        m_wr = 0; m_rd = 0; m_mode = 0; m_hs_v = 0; m_hs_a = 0;
        repeat (3) begin @(posedge clk); #1; end
        check("R1", "reset wr_bank", int'(wr_bank), 0);
        check("R6", "reset rd_bank", int'(rd_bank), 0);
        check("R2", "reset flags", int'(bank_full), 0);
        check("R3", "reset irq", int'(irq), 0);
        check("R5", "reset hs_valid", int'(hs_valid), 0);
        rst_n = 1'b1;
        tick();

        // R1/R2/R5: first payload goes to bank 0 and is acknowledged.
        send_pkt(10, 3, 1'b1);
        check("R5", "first payload ACK", seen_hs_a, 1);
        check("R2", "bank 0 flagged", int'(bank_full), 1);
        read_bank(0, "R7", 10);

        // R1/R6: second payload to bank 1; both flags now set.
        send_pkt(5, 40, 1'b1);
        check("R1", "second payload bank", int'(bank_full), 3);
        check("R6", "both set, service bank 0 first", int'(rd_bank), 0);

        // R8: bank 0 still full, so the third payload is refused.
        send_pkt(8, 90, 1'b1);
        check("R8", "NAK handshake seen", seen_hs_v, 1);
        check("R8", "NAK code", seen_hs_a, 0);
        check("R8", "write pointer held", int'(wr_bank), 0);
        read_bank(0, "R8", 10);

        // R6: clearing bank 1 out of turn does not move the read pointer.
        clear_bank(1);
        check("R6", "pointer after out-of-turn clear", int'(rd_bank), 0);
        check("R4", "only bank 1 cleared", int'(bank_full), 1);
        clear_bank(0);
        check("R6", "pointer after clearing bank 0", int'(rd_bank), 1);

        // R4: clearing an empty bank has no effect.
        clear_bank(0);
        check("R4", "clear of empty bank", int'(bank_full), 0);
        check("R6", "pointer unchanged by empty clear", int'(rd_bank), 1);

        // R9: bad CRC leaves no trace.
        send_pkt(12, 7, 1'b0);
        check("R9", "no handshake", seen_hs_v, 0);
        check("R9", "no flag", int'(bank_full), 0);
        check("R9", "pointer held", int'(wr_bank), 0);

        // R4: a flag holds across idle cycles.
        send_pkt(20, 11, 1'b1);
        repeat (20) tick();
        check("R4", "flag held while idle", int'(bank_full[0]), 1);

        // R11: read bank 0 while a full-size payload fills bank 1.
        cpu_bank = 1'b0;
        concurrent = 1'b1;
        send_pkt(MAX_BYTES, 200, 1'b1);
        concurrent = 1'b0;
        check("R11", "both flagged after concurrent write", int'(bank_full), 3);
        read_bank(0, "R11", 20);
        read_bank(1, "R7", MAX_BYTES);

        // R10: an over-long payload saturates at the bank size.
        clear_bank(1);
        clear_bank(0);
        send_pkt(MAX_BYTES + 6, 55, 1'b1);
        read_bank(0, "R10", MAX_BYTES);

        // R7: a zero-length payload is accepted with count 0.
        send_pkt(0, 0, 1'b1);
        check("R7", "empty payload ACK", seen_hs_a, 1);
        read_bank(1, "R7", 0);
        check("R3", "irq with both flagged", int'(irq), 1);
        clear_bank(0);
        clear_bank(1);
        check("R3", "irq after all cleared", int'(irq), 0);

        done = 1'b1;
        finish_run();
    end

endmodule